// File: doc/BRIEF.md
# Key-Locked Configuration Port with Countdown Watchdog

This block exposes a small register set through two byte-wide host ports: an index port that selects a register, and a data port that reads or writes the register selected. No register can be reached until the host writes a two-byte key to the index port. A separate close code seals the registers again. A page register picks the logical device. The watchdog registers appear only on one page.

The watchdog itself is an 8-bit down-counter. It steps once per seconds tick or once per minutes tick, as the unit bit selects. When it steps from one to zero it raises a reset pulse of fixed width. It then stays at zero until software writes a new timeout. Software keeps the watchdog alive by writing the count register. Keyboard and mouse interrupt activity can also reload the last written timeout, each when its own enable bit is set. Address decoding of the host bus is reduced to a compare against two parameterized port addresses. The tick sources are supplied from outside.

Top module: `cfg_wdog_port`

## Requirements
- R1: After reset the port is locked, the page register is 0x00, the watchdog is disabled, the unit is seconds, the count reads 0x00, both activity reload enables are 0, the index register is 0x00 and the reset output is low.
- R2: Writing 0x87 to the index port (address 0x2E) twice in a row unlocks the port. Any other index write between the two restarts the key sequence. The key writes do not change the index register.
- R3: While locked, data port writes (address 0x2F) change no register, index writes load no index, and a read of either port returns 0xFF.
- R4: While unlocked, writing 0xAA to the index port locks the port again.
- R5: While unlocked, an index port read returns the index register. Index 0x07 is the page register. Indices 0x30, 0xF5, 0xF6 and 0xF7 reach the watchdog only while the page is 0x08. On any other page they read 0x00 and writes to them are ignored.
- R6: Index 0x30 bit 0 enables the watchdog. While it is 0, the count holds through ticks.
- R7: Index 0xF5 bit 3 selects the unit. With 0 the count steps only on the seconds tick, and with 1 only on the minutes tick.
- R8: Writing index 0xF6 loads both the count and the reload value, which acts as a keepalive. Reading 0xF6 returns the current count, and each selected tick lowers it by one.
- R9: Index 0xF7 bit 6 lets a keyboard interrupt reload the count from the reload value, and bit 7 does the same for a mouse interrupt. With a bit clear, that activity leaves the count unchanged.
- R10: A tick that takes the count from 1 to 0 drives the reset output high for PULSE_W (default 4) cycles, starting the cycle after that tick. The count then holds at 0 with the reset output low until 0xF6 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Host port address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while bus_rd_i is high, 0x00 otherwise |
| tick_sec_i | input | 1 | One-cycle seconds tick |
| tick_min_i | input | 1 | One-cycle minutes tick |
| kbd_irq_i | input | 1 | Keyboard interrupt activity |
| mouse_irq_i | input | 1 | Mouse interrupt activity |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The assertions assume the host raises at most one strobe per cycle and holds each write strobe for a single cycle. They also assume each tick and each interrupt line is a pulse of one cycle. The stepping and reload properties hold only under these assumptions. The bench drives every strobe, tick and interrupt from the falling edge for exactly one cycle. It never overlaps a tick with a register write or an interrupt, so each step of the count can be traced to a single cause.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_OPEN_CODE  = 8'h87;
  localparam logic [7:0] KEY_CLOSE_CODE = 8'hAA;
  localparam logic [7:0] IDX_PAGE       = 8'h07;
  localparam logic [7:0] WDOG_PAGE      = 8'h08;
  localparam logic [7:0] IDX_ENABLE     = 8'h30;
  localparam logic [7:0] IDX_UNIT       = 8'hF5;
  localparam logic [7:0] IDX_COUNT      = 8'hF6;
  localparam logic [7:0] IDX_RSTCTL     = 8'hF7;
  localparam logic [7:0] LOCKED_READ    = 8'hFF;
endpackage

// File: rtl/cwp_key_fsm.sv
module cwp_key_fsm
  import cwp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       unlocked_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        KEY_LOCKED: state_d = (wdata_i == KEY_OPEN_CODE) ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   state_d = (wdata_i == KEY_OPEN_CODE) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   state_d = (wdata_i == KEY_CLOSE_CODE) ? KEY_LOCKED : KEY_OPEN;
        default:    state_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_LOCKED;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == KEY_OPEN);

  // R2
  no_early_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr_i && !unlocked_o && wdata_i != KEY_OPEN_CODE) |=> !unlocked_o);

  // R4
  close_code_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr_i && unlocked_o && wdata_i == KEY_CLOSE_CODE) |=> !unlocked_o);
endmodule

// File: rtl/cwp_cfg_regs.sv
module cwp_cfg_regs
  import cwp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          unlocked_i,
  input  logic          idx_wr_i,
  input  logic          dat_wr_i,
  input  logic          idx_rd_i,
  input  logic          dat_rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] count_i,
  output logic          en_o,
  output logic          unit_min_o,
  output logic          kb_en_o,
  output logic          ms_en_o,
  output logic          load_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] idx_q, idx_d;
  logic [DW-1:0] page_q, page_d;
  logic          en_q, en_d;
  logic          unit_q, unit_d;
  logic          kb_q, kb_d;
  logic          ms_q, ms_d;
  logic          wd_page;
  logic          dat_wr_ok;
  logic [DW-1:0] dat_mux;

  assign wd_page   = (page_q == DW'(WDOG_PAGE));
  assign dat_wr_ok = dat_wr_i && unlocked_i;

  always_comb begin
    idx_d  = idx_q;
    page_d = page_q;
    en_d   = en_q;
    unit_d = unit_q;
    kb_d   = kb_q;
    ms_d   = ms_q;
    if (idx_wr_i && unlocked_i && wdata_i != DW'(KEY_CLOSE_CODE)) idx_d = wdata_i;
    if (dat_wr_ok) begin
      if (idx_q == DW'(IDX_PAGE)) page_d = wdata_i;
      if (wd_page) begin
        if (idx_q == DW'(IDX_ENABLE)) en_d = wdata_i[0];
        if (idx_q == DW'(IDX_UNIT))   unit_d = wdata_i[3];
        if (idx_q == DW'(IDX_RSTCTL)) begin
          kb_d = wdata_i[6];
          ms_d = wdata_i[7];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      page_q <= '0;
      en_q   <= 1'b0;
      unit_q <= 1'b0;
      kb_q   <= 1'b0;
      ms_q   <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      page_q <= page_d;
      en_q   <= en_d;
      unit_q <= unit_d;
      kb_q   <= kb_d;
      ms_q   <= ms_d;
    end
  end

  assign load_o = dat_wr_ok && wd_page && (idx_q == DW'(IDX_COUNT));

  always_comb begin
    dat_mux = '0;
    if (idx_q == DW'(IDX_PAGE)) dat_mux = page_q;
    else if (wd_page) begin
      unique case (idx_q)
        DW'(IDX_ENABLE): dat_mux[0] = en_q;
        DW'(IDX_UNIT):   dat_mux[3] = unit_q;
        DW'(IDX_COUNT):  dat_mux = count_i;
        DW'(IDX_RSTCTL): begin
          dat_mux[6] = kb_q;
          dat_mux[7] = ms_q;
        end
        default: dat_mux = '0;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_rd_i)      rdata_o = unlocked_i ? idx_q : DW'(LOCKED_READ);
    else if (dat_rd_i) rdata_o = unlocked_i ? dat_mux : DW'(LOCKED_READ);
  end

  assign en_o       = en_q;
  assign unit_min_o = unit_q;
  assign kb_en_o    = kb_q;
  assign ms_en_o    = ms_q;

  // R3
  locked_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dat_wr_i || idx_wr_i) && !unlocked_i) |=> $stable({idx_q, page_q, en_q, unit_q, kb_q, ms_q}));

  // R5
  off_page_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && !wd_page && idx_q != DW'(IDX_PAGE)) |=> $stable({en_q, unit_q, kb_q, ms_q}));
endmodule

// File: rtl/cwp_wdog_counter.sv
module cwp_wdog_counter #(
  parameter int CW      = 8,
  parameter int PULSE_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          unit_min_i,
  input  logic          tick_sec_i,
  input  logic          tick_min_i,
  input  logic          kb_en_i,
  input  logic          ms_en_i,
  input  logic          kbd_irq_i,
  input  logic          mouse_irq_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] count_o,
  output logic          rst_pulse_o
);
  localparam int PW = $clog2(PULSE_W + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] reload_q, reload_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          tick_sel;
  logic          activity;
  logic          running;
  logic          fire;

  assign tick_sel = unit_min_i ? tick_min_i : tick_sec_i;
  assign activity = (kb_en_i && kbd_irq_i) || (ms_en_i && mouse_irq_i);
  assign running  = en_i && (cnt_q != '0);
  assign fire     = !load_i && running && !activity && tick_sel && (cnt_q == CW'(1));

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    if (load_i) begin
      cnt_d    = load_val_i;
      reload_d = load_val_i;
    end else if (running) begin
      if (activity)      cnt_d = reload_q;
      else if (tick_sel) cnt_d = cnt_q - CW'(1);
    end
  end

  always_comb begin
    pulse_d = pulse_q;
    if (fire)                 pulse_d = PW'(PULSE_W);
    else if (pulse_q != '0)   pulse_d = pulse_q - PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      pulse_q  <= '0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      pulse_q  <= pulse_d;
    end
  end

  assign count_o     = cnt_q;
  assign rst_pulse_o = (pulse_q != '0);

  // R8
  count_never_rises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !activity) |=> (cnt_q <= $past(cnt_q)));

  // R7
  wrong_unit_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !activity && !unit_min_i && tick_min_i && !tick_sec_i) |=> $stable(cnt_q));

  // R6
  disabled_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(cnt_q));

  // R10
  pulse_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_pulse_o) |-> (cnt_q == '0));
endmodule

// File: rtl/cfg_wdog_port.sv
module cfg_wdog_port #(
  parameter int          DW       = 8,
  parameter int          PULSE_W  = 4,
  parameter logic [7:0]  IDX_ADDR = 8'h2E,
  parameter logic [7:0]  DAT_ADDR = 8'h2F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          tick_sec_i,
  input  logic          tick_min_i,
  input  logic          kbd_irq_i,
  input  logic          mouse_irq_i,
  output logic          wdt_rst_o
);
  logic          idx_sel, dat_sel;
  logic          idx_wr, dat_wr, idx_rd, dat_rd;
  logic          unlocked;
  logic          en, unit_min, kb_en, ms_en, load;
  logic [DW-1:0] count;

  assign idx_sel = (bus_addr_i == IDX_ADDR);
  assign dat_sel = (bus_addr_i == DAT_ADDR);
  assign idx_wr  = bus_wr_i && idx_sel;
  assign dat_wr  = bus_wr_i && dat_sel;
  assign idx_rd  = bus_rd_i && idx_sel;
  assign dat_rd  = bus_rd_i && dat_sel;

  cwp_key_fsm u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr),
    .wdata_i    (bus_wdata_i[7:0]),
    .unlocked_o (unlocked)
  );

  cwp_cfg_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .unlocked_i (unlocked),
    .idx_wr_i   (idx_wr),
    .dat_wr_i   (dat_wr),
    .idx_rd_i   (idx_rd),
    .dat_rd_i   (dat_rd),
    .wdata_i    (bus_wdata_i),
    .count_i    (count),
    .en_o       (en),
    .unit_min_o (unit_min),
    .kb_en_o    (kb_en),
    .ms_en_o    (ms_en),
    .load_o     (load),
    .rdata_o    (bus_rdata_o)
  );

  cwp_wdog_counter #(.CW(DW), .PULSE_W(PULSE_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .unit_min_i  (unit_min),
    .tick_sec_i  (tick_sec_i),
    .tick_min_i  (tick_min_i),
    .kb_en_i     (kb_en),
    .ms_en_i     (ms_en),
    .kbd_irq_i   (kbd_irq_i),
    .mouse_irq_i (mouse_irq_i),
    .load_i      (load),
    .load_val_i  (bus_wdata_i),
    .count_o     (count),
    .rst_pulse_o (wdt_rst_o)
  );

  // R3
  locked_read_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && (idx_sel || dat_sel) && !unlocked) |-> (bus_rdata_o == DW'(8'hFF)));
endmodule

// File: tb/cfg_wdog_port_tb_top.sv
module cfg_wdog_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tsec = 1'b0, tmin = 1'b0, kbd = 1'b0, mouse = 1'b0;
  logic       wrst;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  cfg_wdog_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_sec_i(tsec), .tick_min_i(tmin),
    .kbd_irq_i(kbd), .mouse_irq_i(mouse), .wdt_rst_o(wrst)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata; rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    bus_wr(8'h2E, i); bus_wr(8'h2F, d);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] d);
    bus_wr(8'h2E, i); bus_rd(8'h2F, d);
  endtask

  task automatic pulse_sig(input int which);
    @(negedge clk);
    case (which)
      0: tsec = 1'b1; 1: tmin = 1'b1; 2: kbd = 1'b1; default: mouse = 1'b1;
    endcase
    @(negedge clk); tsec = 1'b0; tmin = 1'b0; kbd = 1'b0; mouse = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(8'h2E, 8'h87); bus_wr(8'h2E, 8'h87);
  endtask

  task automatic test_reset();
    logic [7:0] v;
    bus_rd(8'h2E, v); chk("R1 locked index read", v, 8'hFF);
    bus_rd(8'h2F, v); chk("R3 locked data read", v, 8'hFF);
    chk("R1 reset output low", {7'd0, wrst}, 8'h00);
  endtask

  task automatic test_unlock();
    logic [7:0] v;
    bus_wr(8'h2E, 8'h87); bus_wr(8'h2E, 8'h00); bus_wr(8'h2E, 8'h87);
    bus_rd(8'h2E, v); chk("R2 broken key stays locked", v, 8'hFF);
    bus_wr(8'h2E, 8'h87);
    bus_rd(8'h2E, v); chk("R2 unlocked index keeps reset value", v, 8'h00);
    rd_reg(8'h07, v); chk("R1 page reset", v, 8'h00);
    bus_rd(8'h2E, v); chk("R5 index read back", v, 8'h07);
  endtask

  task automatic test_paging();
    logic [7:0] v;
    wr_reg(8'h30, 8'h01);
    rd_reg(8'h30, v); chk("R5 off-page enable reads 0", v, 8'h00);
    wr_reg(8'h07, 8'h08);
    rd_reg(8'h30, v); chk("R5 off-page enable write ignored", v, 8'h00);
    rd_reg(8'hF5, v); chk("R1 unit reset", v, 8'h00);
    rd_reg(8'hF6, v); chk("R1 count reset", v, 8'h00);
    rd_reg(8'hF7, v); chk("R1 reload enables reset", v, 8'h00);
  endtask

  task automatic test_lock();
    logic [7:0] v;
    bus_wr(8'h2E, 8'hF6);
    bus_wr(8'h2E, 8'hAA);
    bus_rd(8'h2F, v); chk("R4 close code locks", v, 8'hFF);
    bus_wr(8'h2F, 8'h44);
    bus_wr(8'h2E, 8'h30);
    unlock();
    bus_rd(8'h2E, v); chk("R3 locked index write ignored", v, 8'hF6);
    bus_rd(8'h2F, v); chk("R3 locked data write ignored", v, 8'h00);
  endtask

  task automatic test_count();
    logic [7:0] v;
    wr_reg(8'hF6, 8'h03);
    rd_reg(8'hF6, v); chk("R8 load readback", v, 8'h03);
    pulse_sig(0);
    rd_reg(8'hF6, v); chk("R6 disabled holds", v, 8'h03);
    wr_reg(8'h30, 8'h01);
    rd_reg(8'h30, v); chk("R6 enable readback", v, 8'h01);
    pulse_sig(1);
    rd_reg(8'hF6, v); chk("R7 minutes tick ignored in seconds", v, 8'h03);
    pulse_sig(0);
    rd_reg(8'hF6, v); chk("R8 seconds step", v, 8'h02);
    wr_reg(8'hF5, 8'h08);
    rd_reg(8'hF5, v); chk("R7 unit readback", v, 8'h08);
    pulse_sig(0);
    rd_reg(8'hF6, v); chk("R7 seconds tick ignored in minutes", v, 8'h02);
    pulse_sig(1);
    rd_reg(8'hF6, v); chk("R7 minutes step", v, 8'h01);
    wr_reg(8'hF5, 8'h00);
  endtask

  task automatic test_activity();
    logic [7:0] v;
    wr_reg(8'hF6, 8'h05);
    pulse_sig(0);
    wr_reg(8'hF7, 8'h00);
    pulse_sig(2);
    rd_reg(8'hF6, v); chk("R9 keyboard ignored when off", v, 8'h04);
    wr_reg(8'hF7, 8'h40);
    pulse_sig(2);
    rd_reg(8'hF6, v); chk("R9 keyboard reload", v, 8'h05);
    pulse_sig(0);
    pulse_sig(3);
    rd_reg(8'hF6, v); chk("R9 mouse ignored when off", v, 8'h04);
    wr_reg(8'hF7, 8'h80);
    pulse_sig(3);
    rd_reg(8'hF6, v); chk("R9 mouse reload", v, 8'h05);
    wr_reg(8'hF7, 8'h00);
  endtask

  task automatic test_expiry();
    logic [7:0] v;
    wr_reg(8'hF6, 8'h01);
    chk("R10 low before expiry", {7'd0, wrst}, 8'h00);
    pulse_sig(0);
    for (int i = 0; i < 4; i++) begin
      chk("R10 pulse high", {7'd0, wrst}, 8'h01);
      @(negedge clk);
    end
    chk("R10 pulse ends", {7'd0, wrst}, 8'h00);
    pulse_sig(0);
    rd_reg(8'hF6, v); chk("R10 count stays zero", v, 8'h00);
    chk("R10 no second pulse", {7'd0, wrst}, 8'h00);
    wr_reg(8'hF6, 8'h02);
    rd_reg(8'hF6, v); chk("R10 reload after expiry", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_unlock();
    test_paging();
    test_lock();
    test_count();
    test_activity();
    test_expiry();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule